// File: doc/BRIEF.md
# Seconds and Cycle Time-of-Day Counter

This block keeps wall-clock time in a reference clock domain as two counters. The seconds counter is 40 bits wide. The sub-second counter counts reference clock cycles from 0 up to one less than the number of cycles in a second. When the sub-second counter rolls over, the seconds counter advances by one and a pulse-per-second output is raised for a set number of cycles. The cycles in a second come from the `REF_PERIOD_PS` parameter as 10^12 / `REF_PERIOD_PS`.

Software stages a new seconds value and a new sub-second value through a small register bus. It then issues one of three load commands:
- load both counters in the same cycle;
- load the seconds counter only;
- load the sub-second counter only.

Loading one counter leaves the other one running. This lets a node that is locked to an outside time source get its seconds number without losing its sub-second phase. The sub-second value is staged as a count of cycles; software converts from nanoseconds.

An optional external-sync mode watches a 1-PPS input. Each rising edge, once synchronised, forces a rollover so that the counter's wrap lines up with the outside pulse. A sticky flag reports that the seconds value has been set at least once since reset, which means the timecode outputs can be trusted.

Top module: `tod_pps_core`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the outputs are zero: `tod_sec`, `tod_cycles`, `pps_out` and `tod_valid`. The external-sync enable and all staged values also reset to zero.
- R2: With no load and no sync edge, `tod_cycles` rises by one each clock. After the value CPS−1 (CPS = 10^12 / `REF_PERIOD_PS`) it returns to 0 and `tod_sec` rises by one in the same clock. A staged cycle value of CPS or more that gets loaded wraps on the next clock.
- R3: A rollover that is not overridden by a cycle load raises `pps_out` for exactly `PPS_WIDTH` clocks, starting with the clock where `tod_cycles` reads 0.
- R4: Writing a word with bit 2 set to address 0 (control) loads both counters at once. The staged seconds and staged cycles show on the outputs after the second rising edge counted from the write's edge.
- R5: Writing a word with bit 3 set to address 1 (sync control) loads only the staged seconds. `tod_cycles` keeps counting without a gap.
- R6: Writing a word with bit 4 set to address 1 loads only the staged cycle value. `tod_sec` is not changed by the load.
- R7: If a seconds load lands in the same clock as a rollover, the loaded value is taken and that clock's increment is dropped. The cycle counter still wraps to 0 and `pps_out` still fires.
- R8: When bit 0 of address 1 (sync enable) is 0, rising edges on `ext_pps_in` have no effect on the counters.
- R9: When sync enable is 1, a rising edge on `ext_pps_in` acts as a rollover: `tod_cycles` becomes 0, `tod_sec` rises by one and `pps_out` fires. This shows on the outputs after the third rising clock edge following the input change. An input held high causes only one rollover.
- R10: `tod_valid` is cleared by reset. It is set by the first seconds load, whether a full load or a seconds-only load, and then stays set until reset. A cycle-only load does not set it. It reads back as bit 2 of address 1.
- R11: Register map and readback:
  - Address 2 holds staged seconds [31:0].
  - Address 3 holds staged seconds [39:32] in bits 7:0; writes keep only those bits.
  - Address 4 holds the staged cycle value.
  - Address 1 returns sync enable in bit 0 and the valid flag in bit 2.
  - The load bits (control bit 2, sync bits 3 and 4) always read 0.
  - Read data appears on `bus_rdata` one clock after the read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write request |
| bus_rd | input | 1 | Register read request |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ext_pps_in | input | 1 | External 1-PPS input (asynchronous) |
| tod_sec | output | 40 | Seconds counter |
| tod_cycles | output | CYC_W | Sub-second cycle counter |
| pps_out | output | 1 | Pulse-per-second output |
| tod_valid | output | 1 | Timecode valid flag |

## Verification
The hardest case to reach is a seconds-only load landing in exactly the clock where the cycle counter wraps. From the ports this depends on the strobe pipeline delay and the counter phase together. The bench waits until the observed cycle count is two short of the wrap, then issues the write. One register stage later the strobe meets the wrap, and the bench expects the staged seconds value instead of an increment. The external-sync latency is handled the same way: the input is raised at a known counter value, and the realignment is expected three edges later.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;
  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_SYNC   = 3'd1,
    A_SEC_LO = 3'd2,
    A_SEC_HI = 3'd3,
    A_CYC    = 3'd4
  } tod_addr_e;

  localparam int B_LOAD_ALL = 2;
  localparam int B_SYNC_EN  = 0;
  localparam int B_VALID    = 2;
  localparam int B_LOAD_SEC = 3;
  localparam int B_LOAD_CYC = 4;

  typedef struct packed {
    logic load_sec;
    logic load_cyc;
  } tod_cmd_t;
endpackage

// File: rtl/tod_regbank.sv
`timescale 1ns/1ps
module tod_regbank
  import tod_pkg::*;
#(
  parameter int SEC_W = 40,
  parameter int CYC_W = 27
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [2:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             valid_in,
  output logic [SEC_W-1:0] stage_sec,
  output logic [CYC_W-1:0] stage_cyc,
  output logic             sync_en,
  output tod_cmd_t         cmd
);
  localparam int HI_W = SEC_W - 32;

  logic [31:0]     sec_lo_q;
  logic [HI_W-1:0] sec_hi_q;
  logic [CYC_W-1:0] cyc_q;
  logic            en_q;
  tod_cmd_t        cmd_q;
  logic            wr_ctrl, wr_sync;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_sync = bus_wr && (bus_addr == A_SYNC);

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_lo_q <= '0;
      sec_hi_q <= '0;
      cyc_q    <= '0;
      en_q     <= 1'b0;
      cmd_q    <= '0;
    end else begin
      cmd_q.load_sec <= (wr_ctrl && bus_wdata[B_LOAD_ALL]) ||
                        (wr_sync && bus_wdata[B_LOAD_SEC]);
      cmd_q.load_cyc <= (wr_ctrl && bus_wdata[B_LOAD_ALL]) ||
                        (wr_sync && bus_wdata[B_LOAD_CYC]);
      if (wr_sync) en_q <= bus_wdata[B_SYNC_EN];
      if (bus_wr && bus_addr == A_SEC_LO) sec_lo_q <= bus_wdata;
      if (bus_wr && bus_addr == A_SEC_HI) sec_hi_q <= bus_wdata[HI_W-1:0];
      if (bus_wr && bus_addr == A_CYC)    cyc_q    <= bus_wdata[CYC_W-1:0];
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_SYNC: begin
        rd_mux[B_SYNC_EN] = en_q;
        rd_mux[B_VALID]   = valid_in;
      end
      A_SEC_LO: rd_mux = sec_lo_q;
      A_SEC_HI: rd_mux[HI_W-1:0] = sec_hi_q;
      A_CYC:    rd_mux[CYC_W-1:0] = cyc_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign stage_sec = {sec_hi_q, sec_lo_q};
  assign stage_cyc = cyc_q;
  assign sync_en   = en_q;
  assign cmd       = cmd_q;
endmodule

// File: rtl/tod_sync_edge.sv
`timescale 1ns/1ps
module tod_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] chain;

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= async_in;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/tod_counters.sv
`timescale 1ns/1ps
module tod_counters
  import tod_pkg::*;
#(
  parameter int          SEC_W     = 40,
  parameter int          CYC_W     = 27,
  parameter longint unsigned CPS   = 125000000,
  parameter int          PPS_WIDTH = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  tod_cmd_t         cmd,
  input  logic [SEC_W-1:0] stage_sec,
  input  logic [CYC_W-1:0] stage_cyc,
  input  logic             sync_en,
  input  logic             sync_rise,
  output logic [SEC_W-1:0] sec,
  output logic [CYC_W-1:0] cyc,
  output logic             pps,
  output logic             valid
);
  localparam logic [CYC_W-1:0] LAST = CYC_W'(CPS - 1);
  localparam int PW_W = $clog2(PPS_WIDTH + 1);

  logic            roll, fire;
  logic [PW_W-1:0] pps_left;

  assign roll = (cyc >= LAST) || (sync_en && sync_rise);
  assign fire = roll && !cmd.load_cyc;

  always_ff @(posedge clk) begin
    if (rst) begin
      sec      <= '0;
      cyc      <= '0;
      pps      <= 1'b0;
      pps_left <= '0;
      valid    <= 1'b0;
    end else begin
      if (cmd.load_cyc)  cyc <= stage_cyc;
      else if (roll)     cyc <= '0;
      else               cyc <= cyc + CYC_W'(1);

      if (cmd.load_sec)  sec <= stage_sec;
      else if (roll)     sec <= sec + SEC_W'(1);

      if (cmd.load_sec)  valid <= 1'b1;

      if (fire) begin
        pps      <= 1'b1;
        pps_left <= PW_W'(PPS_WIDTH - 1);
      end else begin
        pps      <= (pps_left != '0);
        if (pps_left != '0) pps_left <= pps_left - PW_W'(1);
      end
    end
  end
endmodule

// File: rtl/tod_pps_core.sv
`timescale 1ns/1ps
module tod_pps_core
  import tod_pkg::*;
#(
  parameter longint unsigned REF_PERIOD_PS = 8000,
  parameter int PPS_WIDTH   = 1000,
  parameter int SYNC_STAGES = 2,
  parameter int SEC_W       = 40,
  localparam longint unsigned CPS = 64'd1000000000000 / REF_PERIOD_PS,
  localparam int CYC_W      = $clog2(CPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [2:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             ext_pps_in,
  output logic [SEC_W-1:0] tod_sec,
  output logic [CYC_W-1:0] tod_cycles,
  output logic             pps_out,
  output logic             tod_valid
);
  tod_cmd_t         cmd;
  logic [SEC_W-1:0] stage_sec;
  logic [CYC_W-1:0] stage_cyc;
  logic             sync_en, sync_rise;

  tod_regbank #(.SEC_W(SEC_W), .CYC_W(CYC_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .valid_in(tod_valid), .stage_sec(stage_sec), .stage_cyc(stage_cyc),
    .sync_en(sync_en), .cmd(cmd)
  );

  tod_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(ext_pps_in), .rise(sync_rise)
  );

  tod_counters #(.SEC_W(SEC_W), .CYC_W(CYC_W), .CPS(CPS),
                 .PPS_WIDTH(PPS_WIDTH)) u_cnt (
    .clk(clk), .rst(rst), .cmd(cmd), .stage_sec(stage_sec),
    .stage_cyc(stage_cyc), .sync_en(sync_en), .sync_rise(sync_rise),
    .sec(tod_sec), .cyc(tod_cycles), .pps(pps_out), .valid(tod_valid)
  );
endmodule

// File: rtl/tod_pps_checker.sv
`timescale 1ns/1ps
module tod_pps_checker #(
  parameter int SEC_W = 40,
  parameter int CYC_W = 27,
  parameter longint unsigned CPS = 125000000
) (
  input logic             clk,
  input logic             rst,
  input logic [SEC_W-1:0] tod_sec,
  input logic [CYC_W-1:0] tod_cycles,
  input logic             pps_out,
  input logic             tod_valid,
  input logic             load_sec,
  input logic             load_cyc,
  input logic [SEC_W-1:0] stage_sec,
  input logic [CYC_W-1:0] stage_cyc,
  input logic             sync_en,
  input logic             sync_rise
);
  localparam logic [CYC_W-1:0] LAST = CYC_W'(CPS - 1);

  // R2: plain counting step
  p_count_r2: assert property (@(posedge clk) disable iff (rst)
    (!load_sec && !load_cyc && !(sync_en && sync_rise) && tod_cycles < LAST)
    |=> (tod_cycles == $past(tod_cycles) + 1'b1) && $stable(tod_sec));

  // R2: natural wrap
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (!load_sec && !load_cyc && tod_cycles == LAST)
    |=> (tod_cycles == '0) && (tod_sec == $past(tod_sec) + 1'b1));

  // R3: pulse starts at cycle zero
  p_pps_start_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(pps_out) |-> (tod_cycles == '0));

  // R5 and R7: seconds load takes the staged value
  p_secload_r5: assert property (@(posedge clk) disable iff (rst)
    load_sec |=> (tod_sec == $past(stage_sec)));

  // R6: cycle load takes the staged value
  p_cycload_r6: assert property (@(posedge clk) disable iff (rst)
    load_cyc |=> (tod_cycles == $past(stage_cyc)));

  // R8: edge ignored while sync disabled
  p_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (!sync_en && sync_rise && !load_cyc && tod_cycles < LAST)
    |=> (tod_cycles == $past(tod_cycles) + 1'b1));

  // R9: enabled edge forces rollover
  p_realign_r9: assert property (@(posedge clk) disable iff (rst)
    (sync_en && sync_rise && !load_cyc && !load_sec)
    |=> (tod_cycles == '0) && (tod_sec == $past(tod_sec) + 1'b1) && pps_out);

  // R10: valid is sticky and only set by a seconds load
  p_valid_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    tod_valid |=> tod_valid);
  p_valid_set_r10: assert property (@(posedge clk) disable iff (rst)
    (!tod_valid && !load_sec) |=> !tod_valid);
endmodule

bind tod_pps_core tod_pps_checker #(.SEC_W(SEC_W), .CYC_W(CYC_W), .CPS(CPS)) u_chk (
  .clk(clk), .rst(rst), .tod_sec(tod_sec), .tod_cycles(tod_cycles),
  .pps_out(pps_out), .tod_valid(tod_valid), .load_sec(cmd.load_sec),
  .load_cyc(cmd.load_cyc), .stage_sec(stage_sec), .stage_cyc(stage_cyc),
  .sync_en(sync_en), .sync_rise(sync_rise)
);

// File: tb/tod_pps_core_test.sv
`timescale 1ns/1ps
module tod_pps_core_test;
  localparam longint unsigned PER_PS = 64'd10000000000; // 100 cycles per second
  localparam int CPS = 100;
  localparam int PW  = 4;
  localparam int CW  = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic ext_pps_in = 1'b0;
  logic [39:0] tod_sec;
  logic [CW-1:0] tod_cycles;
  logic pps_out, tod_valid;

  tod_pps_core #(.REF_PERIOD_PS(PER_PS), .PPS_WIDTH(PW)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_pps_in(ext_pps_in), .tod_sec(tod_sec), .tod_cycles(tod_cycles),
    .pps_out(pps_out), .tod_valid(tod_valid)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cnum = 0;
  bit done = 0;
  always @(posedge clk) cnum <= cnum + 1;

  // fields: 0 sec, 1 cycles, 2 pps, 3 valid, 4 rdata
  typedef struct { int due; int fld; logic [63:0] exp; string req; } item_t;
  item_t sbq[$];

  function automatic logic [63:0] act_of(int f);
    case (f)
      0: return 64'(tod_sec);
      1: return 64'(tod_cycles);
      2: return 64'(pps_out);
      3: return 64'(tod_valid);
      default: return 64'(bus_rdata);
    endcase
  endfunction

  task automatic chk(string req, logic [63:0] a, logic [63:0] e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, a, e, cnum);
    end
  endtask

  task automatic push(int d, int f, logic [63:0] e, string req);
    item_t it;
    it.due = cnum + d; it.fld = f; it.exp = e; it.req = req;
    sbq.push_back(it);
  endtask

  // monitor: compares every item due in this cycle
  always @(negedge clk) begin
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].due == cnum) begin
        chk(sbq[i].req, act_of(sbq[i].fld), sbq[i].exp);
        sbq.delete(i);
      end
    end
  end

  task automatic bus_write(logic [2:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [2:0] a, logic [31:0] e, string req);
    bus_rd = 1'b1; bus_addr = a;
    push(1, 4, 64'(e), req);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_mid();
    do @(negedge clk); while (!(tod_cycles >= 5 && tod_cycles <= 80));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int c;
    logic [39:0] s;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 sec", 64'(tod_sec), 0);
    chk("R1 cycles", 64'(tod_cycles), 0);
    chk("R1 pps", 64'(pps_out), 0);
    chk("R1 valid", 64'(tod_valid), 0);
    rst = 1'b0;
    // R2 / R3 free running from reset
    push(10, 1, 10, "R2 count");
    push(99, 1, 99, "R2 last");
    push(99, 0, 0, "R2 sec before wrap");
    push(99, 2, 0, "R3 pps low before wrap");
    push(100, 1, 0, "R2 wrap cycles");
    push(100, 0, 1, "R2 wrap sec");
    push(100, 2, 1, "R3 pps start");
    push(100, 3, 0, "R10 no load no valid");
    push(103, 2, 1, "R3 pps last");
    push(104, 2, 0, "R3 pps end");
    repeat (106) @(negedge clk);

    // R4 full load, R11 readback
    bus_write(3'd2, 32'h12345678);
    bus_write(3'd3, 32'h000001AB);
    bus_write(3'd4, 32'd50);
    bus_read(3'd3, 32'h000000AB, "R11 sec hi masked");
    bus_read(3'd4, 32'd50, "R11 cycle stage");
    bus_write(3'd0, 32'h4);
    push(1, 0, 64'hAB12345678, "R4 sec");
    push(1, 1, 50, "R4 cycles");
    push(1, 3, 1, "R10 valid after load");
    push(2, 1, 51, "R4 continue");
    repeat (2) @(negedge clk);
    bus_read(3'd0, 32'h0, "R11 ctrl reads 0");

    // R5 seconds-only load
    bus_write(3'd2, 32'd7);
    bus_write(3'd3, 32'd0);
    wait_mid();
    c = tod_cycles;
    bus_write(3'd1, 32'h8);
    push(1, 0, 7, "R5 sec");
    push(1, 1, 64'(c + 2), "R5 cycles undisturbed");
    repeat (2) @(negedge clk);

    // R6 cycle-only load
    bus_write(3'd4, 32'd20);
    wait_mid();
    s = tod_sec;
    bus_write(3'd1, 32'h10);
    push(1, 1, 20, "R6 cycles");
    push(1, 0, 64'(s), "R6 sec unchanged");
    repeat (2) @(negedge clk);
    bus_read(3'd1, 32'h4, "R11 strobes read 0");

    // R7 seconds load colliding with wrap
    bus_write(3'd2, 32'd500);
    do @(negedge clk); while (tod_cycles != 7'd98);
    bus_write(3'd1, 32'h8);
    push(1, 0, 500, "R7 loaded wins");
    push(1, 1, 0, "R7 wrap");
    push(1, 2, 1, "R7 pps");
    push(2, 0, 500, "R7 no extra increment");
    repeat (3) @(negedge clk);

    // R8 edge ignored with sync disabled
    wait_mid();
    c = tod_cycles; s = tod_sec;
    ext_pps_in = 1'b1;
    push(3, 1, 64'(c + 3), "R8 cycles");
    push(6, 0, 64'(s), "R8 sec");
    push(6, 1, 64'(c + 6), "R8 cycles later");
    repeat (8) @(negedge clk);
    ext_pps_in = 1'b0;
    repeat (4) @(negedge clk);

    // R9 realign with sync enabled
    bus_write(3'd1, 32'h1);
    wait_mid();
    c = tod_cycles; s = tod_sec;
    ext_pps_in = 1'b1;
    push(2, 1, 64'(c + 2), "R9 not yet");
    push(3, 1, 0, "R9 realign");
    push(3, 0, 64'(s + 1), "R9 sec step");
    push(3, 2, 1, "R9 pps");
    push(10, 1, 7, "R9 single rollover");
    push(10, 0, 64'(s + 1), "R9 sec held");
    repeat (12) @(negedge clk);
    ext_pps_in = 1'b0;
    bus_read(3'd1, 32'h5, "R11 sync readback");
    bus_read(3'd2, 32'd500, "R11 sec lo");

    // R10 valid after reset, seconds-only, cycle-only
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 valid reset", 64'(tod_valid), 0);
    chk("R1 sec reset", 64'(tod_sec), 0);
    rst = 1'b0;
    push(1, 1, 1, "R1 cycles after reset");
    bus_read(3'd1, 32'h0, "R1 sync reg reset");
    bus_write(3'd4, 32'd30);
    bus_write(3'd1, 32'h10);
    push(1, 1, 30, "R6 cycles after reset");
    push(1, 3, 0, "R10 cycle load no valid");
    repeat (2) @(negedge clk);
    bus_write(3'd2, 32'd9);
    bus_write(3'd1, 32'h8);
    push(1, 0, 9, "R5 sec after reset");
    push(1, 3, 1, "R10 valid via sec load");
    repeat (2) @(negedge clk);
    bus_write(3'd1, 32'h10);
    push(1, 3, 1, "R10 valid sticky");
    repeat (4) @(negedge clk);

    while (sbq.size() > 0) begin
      fails++;
      $display("FAIL %s actual=missing expected=%0h", sbq[0].req, sbq[0].exp);
      void'(sbq.pop_front());
    end
    done = 1;
    finish_run();
  end
endmodule